// File: doc/BRIEF.md
# Tagged Local-History Direction Predictor

This block predicts whether a conditional branch will be taken. It works in two levels. The first level is a direct-mapped cache of per-branch history registers. The low bits of the branch address select an entry, and a partial tag taken from higher address bits confirms which branch owns it. The second level is one array of 2-bit saturating counters that all history entries share. A counter is selected by XORing the branch's history with low address bits. The XOR spreads branches that have the same recent pattern across different counters.

The fetch side presents an address with a valid strobe. One cycle later the block returns a valid flag, a hit flag and a taken prediction. The resolve side presents an address and the real outcome. On a hit it trains the selected counter and shifts the outcome into that branch's history. On a miss it claims the entry for the new branch. Both sides work in the same cycle. A lookup always sees the state as it was before that cycle's resolve.

Top module: `bp_local_predictor`

## Requirements
- R1: After reset, every history entry is invalid, `pred_valid` is low, and every counter holds weak taken (2'b10). A newly allocated branch therefore predicts taken on its first hit.
- R2: `pred_valid` is high exactly one cycle after a cycle with `lk_valid` high. While `pred_valid` is low, `pred_hit` and `pred_taken` are low.
- R3: With the default parameters, the entry index is address bits [11:2] and the tag is bits [19:12]. A lookup hits when the selected entry is valid and its stored tag equals the tag bits of the address.
- R4: A lookup that misses predicts not-taken.
- R5: A lookup that hits predicts the MSB of the counter selected by history XOR address bits [7:2].
- R6: On a resolve that hits, the selected counter moves one step toward the outcome. It increments on taken and decrements on not-taken, saturating at 2'b11 and 2'b00. The encodings are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken.
- R7: On a resolve that hits, the 6-bit history shifts left by one. The outcome enters at bit 0 and the old bit 5 is dropped.
- R8: On a resolve that misses, the entry takes the new tag and its history becomes zero. No counter changes. A different branch that mapped to the same entry is evicted.
- R9: When a lookup and a resolve occur in the same cycle, the lookup returns the history and counter values as they were before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Fetch lookup request |
| lk_addr | input | 32 | Address of the branch being looked up |
| pred_valid | output | 1 | Prediction present (one cycle after request) |
| pred_hit | output | 1 | History entry matched the tag |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| rs_valid | input | 1 | Resolved branch strobe |
| rs_addr | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
Lookup and resolve can land in the same cycle on the same branch. In that case they also touch the same history entry and the same counter. The bench provokes this directly, by issuing both for one address in a single cycle, and by random traffic over a few addresses that share entries. A behavioural model predicts the lookup from the state before the resolve and applies the update afterwards, so any leakage of the new value into the lookup shows up as a mismatch on that cycle's prediction.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  function automatic ctr_t ctr_step(ctr_t cur, logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_t'(cur + 2'b01);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_t'(cur - 2'b01);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bp_hist_cache.sv
module bp_hist_cache #(
  parameter int ADDR_W = 32,
  parameter int ALIGN  = 2,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 8,
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  output logic              up_hit,
  output logic [HIST_W-1:0] up_hist
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LO  = ALIGN + IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [HIST_W-1:0]  hist_q [ENTRIES];

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic [HIST_W-1:0] wr_hist;

  always_comb begin
    lk_idx  = lk_addr[ALIGN +: IDX_W];
    lk_tag  = lk_addr[TAG_LO +: TAG_W];
    up_idx  = up_addr[ALIGN +: IDX_W];
    up_tag  = up_addr[TAG_LO +: TAG_W];
    lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    lk_hist = hist_q[lk_idx];
    up_hit  = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
    up_hist = hist_q[up_idx];
    if (up_hit) wr_hist = {up_hist[HIST_W-2:0], up_taken};
    else        wr_hist = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (up_en) begin
      valid_q[up_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (up_en) begin
      tag_q[up_idx]  <= up_tag;
      hist_q[up_idx] <= wr_hist;
    end
  end

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] lk_idx,
  output ctr_t              lk_ctr,
  input  logic              up_en,
  input  logic [HIST_W-1:0] up_idx,
  input  logic              up_taken
);

  localparam int CNT = 1 << HIST_W;

  ctr_t ctr_arr [CNT];

  for (genvar g = 0; g < CNT; g++) begin : g_ctr
    ctr_t q, d;
    logic en;

    always_comb begin
      en = up_en && (up_idx == HIST_W'(g));
      d  = ctr_step(q, up_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= CTR_WT;
      else if (en) q <= d;
    end

    assign ctr_arr[g] = q;
  end

  assign lk_ctr = ctr_arr[lk_idx];

endmodule

// File: rtl/bp_local_predictor.sv
module bp_local_predictor
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ALIGN  = 2,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 8,
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_taken,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic              rs_taken
);

  logic              lk_hit, up_hit;
  logic [HIST_W-1:0] lk_hist, up_hist;
  logic [HIST_W-1:0] lk_cidx, up_cidx;
  logic              ctr_up_en;
  ctr_t              lk_ctr;

  logic pv_d, ph_d, pt_d;
  logic pv_q, ph_q, pt_q;

  bp_hist_cache #(
    .ADDR_W(ADDR_W), .ALIGN(ALIGN), .IDX_W(IDX_W),
    .TAG_W(TAG_W), .HIST_W(HIST_W)
  ) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (lk_addr),
    .lk_hit   (lk_hit),
    .lk_hist  (lk_hist),
    .up_en    (rs_valid),
    .up_addr  (rs_addr),
    .up_taken (rs_taken),
    .up_hit   (up_hit),
    .up_hist  (up_hist)
  );

  always_comb begin
    lk_cidx   = lk_hist ^ lk_addr[ALIGN +: HIST_W];
    up_cidx   = up_hist ^ rs_addr[ALIGN +: HIST_W];
    ctr_up_en = rs_valid && up_hit;
  end

  bp_ctr_table #(.HIST_W(HIST_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (lk_cidx),
    .lk_ctr   (lk_ctr),
    .up_en    (ctr_up_en),
    .up_idx   (up_cidx),
    .up_taken (rs_taken)
  );

  always_comb begin
    pv_d = lk_valid;
    ph_d = lk_valid && lk_hit;
    pt_d = lk_valid && lk_hit && lk_ctr[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      ph_q <= 1'b0;
      pt_q <= 1'b0;
    end else begin
      pv_q <= pv_d;
      ph_q <= ph_d;
      pt_q <= pt_d;
    end
  end

  assign pred_valid = pv_q;
  assign pred_hit   = ph_q;
  assign pred_taken = pt_q;

endmodule

// File: rtl/bp_local_predictor_chk.sv
module bp_local_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              pred_valid,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_addr
);

  assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);

  assert_idle_no_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);

  assert_quiet_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> (!pred_hit && !pred_taken));

  assert_miss_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_hit) |-> !pred_taken);

  assert_alloc_then_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid ##1 (lk_valid && lk_addr == $past(rs_addr))) |=> pred_hit);

endmodule

bind bp_local_predictor bp_local_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_addr    (lk_addr),
  .pred_valid (pred_valid),
  .pred_hit   (pred_hit),
  .pred_taken (pred_taken),
  .rs_valid   (rs_valid),
  .rs_addr    (rs_addr)
);

// File: tb/tb_bp_local_predictor.sv
module tb_bp_local_predictor;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        pred_valid, pred_hit, pred_taken;
  logic        rs_valid;
  logic [31:0] rs_addr;
  logic        rs_taken;

  int n_checks = 0;
  int n_errors = 0;

  bit       m_valid [1024];
  int       m_tag   [1024];
  int       m_hist  [1024];
  int       m_ctr   [64];

  bp_local_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int f_idx(logic [31:0] a); return int'((a >> 2) & 32'h3FF); endfunction
  function automatic int f_tag(logic [31:0] a); return int'((a >> 12) & 32'hFF); endfunction
  function automatic int f_low(logic [31:0] a); return int'((a >> 2) & 32'h3F); endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit lv, logic [31:0] la, bit rv, logic [31:0] ra, bit rt, string tg);
    bit e_hit, e_tk;
    int i;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; rs_valid = rv; rs_addr = ra; rs_taken = rt;
    i     = f_idx(la);
    e_hit = lv && m_valid[i] && (m_tag[i] == f_tag(la));
    e_tk  = e_hit && (m_ctr[m_hist[i] ^ f_low(la)] >= 2);
    if (rv) begin
      int j;
      j = f_idx(ra);
      if (m_valid[j] && m_tag[j] == f_tag(ra)) begin
        int c;
        c = m_hist[j] ^ f_low(ra);
        if (rt) begin if (m_ctr[c] < 3) m_ctr[c]++; end
        else    begin if (m_ctr[c] > 0) m_ctr[c]--; end
        m_hist[j] = ((m_hist[j] << 1) | int'(rt)) & 63;
      end else begin
        m_valid[j] = 1'b1;
        m_tag[j]   = f_tag(ra);
        m_hist[j]  = 0;
      end
    end
    @(posedge clk);
    #1;
    check("R2 valid", pred_valid, lv);
    check("R3 hit", pred_hit, e_hit);
    check(e_hit ? tg : "R4", pred_taken, e_tk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] pool [6];
    logic [31:0] A, B, C;
    A = 32'h0001_0040;
    B = 32'h0002_0040;
    C = 32'h0005_3A8C;
    pool[0] = A; pool[1] = B; pool[2] = C;
    pool[3] = 32'h0001_0044; pool[4] = 32'h0007_F100; pool[5] = 32'h0003_0140;
    for (int k = 0; k < 1024; k++) begin m_valid[k] = 1'b0; m_tag[k] = 0; m_hist[k] = 0; end
    for (int k = 0; k < 64; k++) m_ctr[k] = 2;

    lk_valid = 0; lk_addr = '0; rs_valid = 0; rs_addr = '0; rs_taken = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset pred_valid", pred_valid, 1'b0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    check("R1 idle after reset", pred_valid, 1'b0);

    // R4: cold lookup misses and predicts not-taken
    step(1, A, 0, '0, 0, "R4");
    // R8: resolve miss allocates
    step(0, '0, 1, A, 1, "R8");
    // R1: first hit reads weak-taken counter
    step(1, A, 0, '0, 0, "R1");
    // R6 / R7: train taken runs, lookups each cycle
    for (int k = 0; k < 8; k++) step(1, A, 1, A, 1, "R6");
    step(1, A, 0, '0, 0, "R6");
    for (int k = 0; k < 4; k++) begin
      step(0, '0, 1, A, 0, "R7");
      step(1, A, 0, '0, 0, "R7");
    end
    // R7: alternating pattern
    for (int k = 0; k < 12; k++) step(1, A, 1, A, k[0], "R7");
    // R9: same-cycle lookup and resolve, then lookup
    step(1, A, 1, A, 0, "R9");
    step(1, A, 1, A, 0, "R9");
    step(1, A, 0, '0, 0, "R9");
    // R8: aliasing branch evicts A
    step(0, '0, 1, B, 0, "R8");
    step(1, A, 0, '0, 0, "R8");
    step(1, B, 0, '0, 0, "R8");
    // R5: independent branch
    step(0, '0, 1, C, 0, "R5");
    for (int k = 0; k < 6; k++) step(1, C, 1, C, 0, "R5");
    step(1, C, 0, '0, 0, "R6");
    // R5 / R9: random mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int ia, ib;
      ia = int'($urandom_range(0, 5));
      ib = int'($urandom_range(0, 5));
      step(bit'($urandom_range(0, 1)), pool[ia], bit'($urandom_range(0, 1)),
           pool[ib], bit'($urandom_range(0, 1)), "R5");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule